// File: doc/BRIEF.md
# MESI Snooping Cache Coherence Controller

This block keeps one private cache consistent with its peers on a shared snooping bus under a four-state write-back invalidate protocol. It holds a small direct-mapped store in which every line carries a tag, one data word and a coherence state: Modified (sole, dirty), Exclusive (sole, clean), Shared (clean, possibly held elsewhere) or Invalid. The processor side issues reads, writes and replaces. The controller answers from the store when it can. Otherwise it raises one or two bus transactions and answers once the last of them has been granted.

The snoop side watches transactions made by other caches. When a snooped read finds a valid local copy, the controller drives a wired-OR shared indication in the same cycle. When the snooped line is dirty, the controller supplies its data on a flush output. The state change takes effect at the next clock edge. On its own read misses the controller samples the shared line during the granted cycle. From that sample it installs the line as Shared or as Exclusive, which later lets a write to an Exclusive line complete with no bus traffic.

The processor request and the bus request are valid/ready channels. A request whose valid is high stays presented until ready is seen high at a clock edge, and that edge is the transfer. The processor response is a one-cycle pulse with no back-pressure. The controller accepts a new processor request only after the previous response. Snoops never see this cache's own transactions, and no snoop is presented in a cycle where this cache is granted.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, the processor port is ready, no bus request is raised, no response is given, and a snoop to any address drives shared, flush and error low.
- R2: A read that misses raises a bus read (command code 0) for its address. The line is filled from the bus read data at the grant edge and becomes Shared if the shared input is high in that cycle and Exclusive if it is low. The response returns the filled word.
- R3: A read hit in Modified, Exclusive or Shared, and a write hit in Exclusive or Modified, raise no bus request, and the response pulse comes in the second cycle after the request is accepted. A write hit leaves the line Modified and holding the written word.
- R4: A write that misses raises a read-exclusive (code 1). A write to a Shared line raises an upgrade (code 2) that carries no data. Both leave the line Modified with the written word, and the response returns that word.
- R5: If a line with a pending upgrade is invalidated by a snoop while the upgrade waits for its grant, the request turns into a read-exclusive for the same address from the next cycle on.
- R6: A snooped bus read (code 0) that matches a valid line raises the shared output in that cycle and leaves the line Shared. A Modified line also asserts flush with its data in that cycle.
- R7: A snooped read-exclusive (code 1) that matches invalidates the line and flushes its data if it was Modified. A snooped upgrade (code 2) that matches an Exclusive or Shared line invalidates it without a flush.
- R8: A snooped upgrade that matches a Modified line asserts the error output in that cycle, with no flush and no shared, and the line stays Modified.
- R9: A replace (processor op code 2) of a Modified line raises a write-back (code 3) with the line's address and data. A replace of any other valid line is silent. A replace of an absent address changes nothing. In every case a response follows, and a matching line ends Invalid.
- R10: A read or write whose index holds a Modified line with another tag first writes that victim back at the victim's own address, then issues its own request. A clean victim is dropped silently.
- R11: A raised bus request keeps valid high and its address stable until granted. Processor op codes are 0 read, 1 write, 2 replace; code 3 is handled as a read.
- R12: Snoops of a write-back, snoops that match no valid line and cycles with no snoop drive shared, flush and error low and leave the store unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_op | input | 2 | 0 read, 1 write, 2 replace, 3 read |
| cpu_req_addr | input | ADDR_W | Request address (low bits index the store) |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_data | output | DATA_W | Read or written word (zero for replace) |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_ready | input | 1 | Grant; transaction happens in this cycle |
| bus_req_cmd | output | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 write-back |
| bus_req_addr | output | ADDR_W | Transaction address |
| bus_req_wdata | output | DATA_W | Write-back data |
| bus_rd_data | input | DATA_W | Fill data, sampled at grant |
| bus_shared_in | input | 1 | Wired-OR shared line, sampled at grant |
| snp_valid | input | 1 | Another cache's transaction is visible |
| snp_cmd | input | 2 | Snooped command, same codes as bus_req_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared_out | output | 1 | Drives the shared line |
| snp_flush_valid | output | 1 | Dirty data supplied this cycle |
| snp_flush_data | output | DATA_W | Flushed word |
| snp_err | output | 1 | Upgrade snooped against a Modified line |

## Verification
A request answered from the store gives its response in the second cycle after the accepting edge. A request that needs the bus gives its response in the cycle after its final grant. Snoop outputs are combinational in the snooped cycle, and the resulting state change appears from the next edge on. The bench drives inputs on falling edges and counts falling edges from acceptance. It samples snoop outputs a quarter period after driving them and checks each bus command and address at the cycle it grants. The response must land on the exact counted cycle, and every state effect is confirmed through later processor or snoop traffic.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} coh_state_e;
  typedef enum logic [1:0] {BC_RD = 2'd0, BC_RDX = 2'd1, BC_UPGR = 2'd2, BC_WB = 2'd3} bus_cmd_e;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_WRITE = 2'd1, OP_REPLACE = 2'd2, OP_ALTREAD = 2'd3} cpu_op_e;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output coh_state_e        a_state,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic              a_we,
  input  coh_state_e        a_wstate,
  input  logic [TAG_W-1:0]  a_wtag,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic [IDX_W-1:0]  b_idx,
  output coh_state_e        b_state,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              b_we,
  input  coh_state_e        b_wstate
);
  coh_state_e        st_all  [LINES];
  logic [TAG_W-1:0]  tag_all [LINES];
  logic [DATA_W-1:0] dat_all [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    coh_state_e        st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] dat_q;
    logic              sel_a, sel_b;

    assign sel_a = a_we && (a_idx == IDX_W'(g));
    assign sel_b = b_we && (b_idx == IDX_W'(g));

    // processor port wins when both ports address one line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q <= ST_I;
      else if (sel_a) st_q <= a_wstate;
      else if (sel_b) st_q <= b_wstate;
    end

    always_ff @(posedge clk) begin
      if (sel_a) begin
        tag_q <= a_wtag;
        dat_q <= a_wdata;
      end
    end

    assign st_all[g]  = st_q;
    assign tag_all[g] = tag_q;
    assign dat_all[g] = dat_q;
  end

  assign a_state = st_all[a_idx];
  assign a_tag   = tag_all[a_idx];
  assign a_data  = dat_all[a_idx];
  assign b_state = st_all[b_idx];
  assign b_tag   = tag_all[b_idx];
  assign b_data  = dat_all[b_idx];

  AST_PORT_A_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we && b_we && a_idx == b_idx) |=> (a_state == $past(a_wstate))) else $error("port priority"); // R12
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  coh_state_e        line_state,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              shared_out,
  output logic              flush_valid,
  output logic [DATA_W-1:0] flush_data,
  output logic              err,
  output logic              upd_en,
  output coh_state_e        upd_state
);
  logic match;
  logic dirty;

  assign match      = snp_valid && (line_state != ST_I) && (line_tag == snp_tag);
  assign dirty      = (line_state == ST_M);
  assign flush_data = line_data;

  always_comb begin
    shared_out  = 1'b0;
    flush_valid = 1'b0;
    err         = 1'b0;
    upd_en      = 1'b0;
    upd_state   = line_state;
    if (match) begin
      case (bus_cmd_e'(snp_cmd))
        BC_RD: begin
          shared_out  = 1'b1;
          flush_valid = dirty;
          upd_en      = 1'b1;
          upd_state   = ST_S;
        end
        BC_RDX: begin
          flush_valid = dirty;
          upd_en      = 1'b1;
          upd_state   = ST_I;
        end
        BC_UPGR: begin
          if (dirty) begin
            err = 1'b1;
          end else begin
            upd_en    = 1'b1;
            upd_state = ST_I;
          end
        end
        default: ;
      endcase
    end
  end

  AST_ERR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!flush_valid && !shared_out && !upd_en)) else $error("err with side effects"); // R8
  AST_FLUSH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (snp_cmd == BC_RD || snp_cmd == BC_RDX)) else $error("flush on wrong cmd"); // R7
endmodule

// File: rtl/mesi_req_path.sv
module mesi_req_path
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic [1:0]        cpu_req_op,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_data,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_wdata,
  input  logic [DATA_W-1:0] bus_rd_data,
  input  logic              bus_shared_in,
  input  logic              snp_collide,
  output logic [IDX_W-1:0]  line_idx,
  input  coh_state_e        line_state,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              st_we,
  output coh_state_e        st_wstate,
  output logic [TAG_W-1:0]  st_wtag,
  output logic [DATA_W-1:0] st_wdata
);
  typedef enum logic [1:0] {PH_IDLE, PH_LOOK, PH_BUS} phase_e;

  phase_e            ph_q, ph_d;
  cpu_op_e           op_q;
  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] wdata_q;
  logic              evict_q, evict_d;
  logic              rsp_set;
  logic [DATA_W-1:0] rsp_val;
  logic              hit, is_wr, is_rep;

  assign line_idx      = idx_q;
  assign cpu_req_ready = (ph_q == PH_IDLE);
  assign hit    = (line_state != ST_I) && (line_tag == tag_q);
  assign is_wr  = (op_q == OP_WRITE);
  assign is_rep = (op_q == OP_REPLACE);

  // bus request side: command re-derived every cycle from the live line state
  assign bus_req_valid = (ph_q == PH_BUS);
  assign bus_req_wdata = evict_q ? line_data : '0;
  assign bus_req_addr  = evict_q ? {line_tag, idx_q} : {tag_q, idx_q};
  always_comb begin
    if (evict_q)                         bus_req_cmd = BC_WB;
    else if (!is_wr)                     bus_req_cmd = BC_RD;
    else if (hit && line_state == ST_S)  bus_req_cmd = BC_UPGR;
    else                                 bus_req_cmd = BC_RDX;
  end

  always_comb begin
    ph_d      = ph_q;
    evict_d   = evict_q;
    st_we     = 1'b0;
    st_wstate = line_state;
    st_wtag   = line_tag;
    st_wdata  = line_data;
    rsp_set   = 1'b0;
    rsp_val   = '0;
    case (ph_q)
      PH_IDLE: if (cpu_req_valid) ph_d = PH_LOOK;
      PH_LOOK: if (!snp_collide) begin
        if (is_rep) begin
          if (hit && line_state == ST_M) begin
            ph_d    = PH_BUS;
            evict_d = 1'b1;
          end else begin
            st_we     = hit;
            st_wstate = ST_I;
            rsp_set   = 1'b1;
            ph_d      = PH_IDLE;
          end
        end else if (is_wr && hit && (line_state == ST_M || line_state == ST_E)) begin
          st_we     = 1'b1;
          st_wstate = ST_M;
          st_wdata  = wdata_q;
          rsp_set   = 1'b1;
          rsp_val   = wdata_q;
          ph_d      = PH_IDLE;
        end else if (!is_wr && hit) begin
          rsp_set = 1'b1;
          rsp_val = line_data;
          ph_d    = PH_IDLE;
        end else begin
          ph_d    = PH_BUS;
          evict_d = !hit && (line_state == ST_M);
        end
      end
      PH_BUS: if (bus_req_ready) begin
        st_we = 1'b1;
        if (evict_q) begin
          st_wstate = ST_I;
          evict_d   = 1'b0;
          if (is_rep) begin
            rsp_set = 1'b1;
            ph_d    = PH_IDLE;
          end
        end else begin
          st_wtag = tag_q;
          rsp_set = 1'b1;
          ph_d    = PH_IDLE;
          if (is_wr) begin
            st_wstate = ST_M;
            st_wdata  = wdata_q;
            rsp_val   = wdata_q;
          end else begin
            st_wstate = bus_shared_in ? ST_S : ST_E;
            st_wdata  = bus_rd_data;
            rsp_val   = bus_rd_data;
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q          <= PH_IDLE;
      evict_q       <= 1'b0;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_data  <= '0;
      op_q          <= OP_READ;
      tag_q         <= '0;
      idx_q         <= '0;
      wdata_q       <= '0;
    end else begin
      ph_q          <= ph_d;
      evict_q       <= evict_d;
      cpu_rsp_valid <= rsp_set;
      if (rsp_set) cpu_rsp_data <= rsp_val;
      if (ph_q == PH_IDLE && cpu_req_valid) begin
        op_q    <= cpu_op_e'(cpu_req_op);
        tag_q   <= cpu_req_addr[ADDR_W-1:IDX_W];
        idx_q   <= cpu_req_addr[IDX_W-1:0];
        wdata_q <= cpu_req_wdata;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready) |=> bus_req_valid) else $error("request dropped"); // R11
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready) |=> $stable(bus_req_addr)) else $error("address moved"); // R11
  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_LOOK && !snp_collide && hit && !is_wr && !is_rep) |=> (cpu_rsp_valid && !bus_req_valid))
    else $error("read hit used bus"); // R3
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> (!cpu_rsp_valid && cpu_req_ready)) else $error("response not a pulse"); // R3
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic [1:0]        cpu_req_op,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_data,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_wdata,
  input  logic [DATA_W-1:0] bus_rd_data,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared_out,
  output logic              snp_flush_valid,
  output logic [DATA_W-1:0] snp_flush_data,
  output logic              snp_err
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  pa_idx;
  coh_state_e        pa_state, pa_wstate, pb_state, pb_wstate;
  logic [TAG_W-1:0]  pa_tag, pa_wtag, pb_tag;
  logic [DATA_W-1:0] pa_data, pa_wdata, pb_data;
  logic              pa_we, pb_we;
  logic [IDX_W-1:0]  snp_idx;
  logic [TAG_W-1:0]  snp_tag;
  logic              snp_collide;

  assign snp_idx     = snp_addr[IDX_W-1:0];
  assign snp_tag     = snp_addr[ADDR_W-1:IDX_W];
  assign snp_collide = snp_valid && (snp_idx == pa_idx);

  mesi_line_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(pa_idx), .a_state(pa_state), .a_tag(pa_tag), .a_data(pa_data),
    .a_we(pa_we), .a_wstate(pa_wstate), .a_wtag(pa_wtag), .a_wdata(pa_wdata),
    .b_idx(snp_idx), .b_state(pb_state), .b_tag(pb_tag), .b_data(pb_data),
    .b_we(pb_we), .b_wstate(pb_wstate)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(snp_tag),
    .line_state(pb_state), .line_tag(pb_tag), .line_data(pb_data),
    .shared_out(snp_shared_out), .flush_valid(snp_flush_valid), .flush_data(snp_flush_data),
    .err(snp_err), .upd_en(pb_we), .upd_state(pb_wstate)
  );

  mesi_req_path #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_op(cpu_req_op),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_data(cpu_rsp_data),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready), .bus_req_cmd(bus_req_cmd),
    .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
    .bus_rd_data(bus_rd_data), .bus_shared_in(bus_shared_in),
    .snp_collide(snp_collide),
    .line_idx(pa_idx), .line_state(pa_state), .line_tag(pa_tag), .line_data(pa_data),
    .st_we(pa_we), .st_wstate(pa_wstate), .st_wtag(pa_wtag), .st_wdata(pa_wdata)
  );

  AST_SNOOP_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_valid |-> (!snp_shared_out && !snp_flush_valid && !snp_err)) else $error("snoop output w/o snoop"); // R12
endmodule

// File: tb/mesi_snoop_ctrl_test.sv
module mesi_snoop_ctrl_test;
  localparam int CLK_NS = 10;
  localparam int AW = 8, DW = 16, NL = 8;
  localparam int MI = 0, MS = 1, ME = 2, MM = 3;

  logic clk = 0, rst_n = 0;
  logic cpu_req_valid = 0, cpu_req_ready;
  logic [1:0] cpu_req_op = 0;
  logic [AW-1:0] cpu_req_addr = 0;
  logic [DW-1:0] cpu_req_wdata = 0;
  logic cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_data;
  logic bus_req_valid, bus_req_ready = 0;
  logic [1:0] bus_req_cmd;
  logic [AW-1:0] bus_req_addr;
  logic [DW-1:0] bus_req_wdata, bus_rd_data = 0;
  logic bus_shared_in = 0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = 0;
  logic [AW-1:0] snp_addr = 0;
  logic snp_shared_out, snp_flush_valid, snp_err;
  logic [DW-1:0] snp_flush_data;

  int n_cmp = 0, n_bad = 0;
  int m_st [NL];
  logic [4:0] m_tag [NL];
  logic [DW-1:0] m_dat [NL];

  always #(CLK_NS/2) clk = ~clk;

  mesi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) uut (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_hit(logic [AW-1:0] a);
    return m_st[a[2:0]] != MI && m_tag[a[2:0]] == a[7:3];
  endfunction

  function automatic int snoop_next(int st, logic [1:0] cmd);
    if (cmd == 2'd0) return MS;
    if (cmd == 2'd1) return MI;
    if (cmd == 2'd2) return (st == MM) ? MM : MI;
    return st;
  endfunction

  task automatic do_cpu(string req, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] wd, logic sh);
    int idx = a[2:0];
    logic [1:0] ecmd [2];
    logic [AW-1:0] eadr [2];
    logic [DW-1:0] edat [2];
    int nexp = 0, seen = 0, lat = 1, lat_g = 0, wt;
    bit h = is_hit(a);
    logic [DW-1:0] fill = DW'($urandom), exp_rsp;
    logic [1:0] eop = (op == 2'd3) ? 2'd0 : op;
    if (eop != 2'd2 && !h && m_st[idx] == MM) begin
      ecmd[0] = 2'd3; eadr[0] = {m_tag[idx], 3'(idx)}; edat[0] = m_dat[idx]; nexp = 1;
    end
    if (eop == 2'd0 && !h) begin ecmd[nexp] = 2'd0; eadr[nexp] = a; edat[nexp] = 0; nexp++; end
    if (eop == 2'd1 && !(h && m_st[idx] >= ME)) begin
      ecmd[nexp] = (h && m_st[idx] == MS) ? 2'd2 : 2'd1; eadr[nexp] = a; edat[nexp] = 0; nexp++;
    end
    if (eop == 2'd2 && h && m_st[idx] == MM) begin
      ecmd[0] = 2'd3; eadr[0] = a; edat[0] = m_dat[idx]; nexp = 1;
    end
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_op = op; cpu_req_addr = a; cpu_req_wdata = wd;
    #1 chk(req, "ready", cpu_req_ready, 1);
    @(negedge clk);
    cpu_req_valid = 0;
    wt = $urandom % 3;
    while (1) begin
      bus_req_ready = 0;
      if (cpu_rsp_valid || lat > 40) break;
      if (bus_req_valid) begin
        if (wt == 0) begin
          if (seen < nexp) begin
            chk(req, "bus cmd", bus_req_cmd, ecmd[seen]);
            chk(req, "bus addr", bus_req_addr, eadr[seen]);
            if (ecmd[seen] == 2'd3) chk(req, "wb data", bus_req_wdata, edat[seen]);
          end else chk(req, "unexpected bus req", 1, 0);
          bus_req_ready = 1; bus_rd_data = fill; bus_shared_in = sh;
          seen++; lat_g = lat; wt = $urandom % 3;
        end else wt--;
      end
      @(negedge clk);
      lat++;
    end
    chk(req, "bus count", seen, nexp);
    if (nexp == 0) chk(req, "hit latency", lat, 2);
    else chk(req, "bus latency", lat, lat_g + 1);
    if (eop == 2'd2) begin
      exp_rsp = 0;
      if (h) m_st[idx] = MI;
    end else if (eop == 2'd1) begin
      exp_rsp = wd; m_st[idx] = MM; m_tag[idx] = a[7:3]; m_dat[idx] = wd;
    end else if (h) exp_rsp = m_dat[idx];
    else begin
      exp_rsp = fill; m_st[idx] = sh ? MS : ME; m_tag[idx] = a[7:3]; m_dat[idx] = fill;
    end
    chk(req, "rsp data", cpu_rsp_data, exp_rsp);
  endtask

  task automatic do_snoop(string req, logic [1:0] cmd, logic [AW-1:0] a);
    int idx = a[2:0];
    bit h = is_hit(a) && cmd != 2'd3;
    @(negedge clk);
    snp_valid = 1; snp_cmd = cmd; snp_addr = a;
    #(CLK_NS/4);
    chk(req, "snoop shared", snp_shared_out, h && cmd == 2'd0);
    chk(req, "snoop flush", snp_flush_valid, h && m_st[idx] == MM && cmd <= 2'd1);
    if (h && m_st[idx] == MM && cmd <= 2'd1) chk(req, "flush data", snp_flush_data, m_dat[idx]);
    chk(req, "snoop err", snp_err, h && m_st[idx] == MM && cmd == 2'd2);
    if (h) m_st[idx] = snoop_next(m_st[idx], cmd);
    @(negedge clk);
    snp_valid = 0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NL; i++) begin m_st[i] = MI; m_tag[i] = 0; m_dat[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "ready", cpu_req_ready, 1);
    chk("R1", "bus valid", bus_req_valid, 0);
    chk("R1", "rsp valid", cpu_rsp_valid, 0);
    do_snoop("R1", 2'd0, 8'h0B);
    // exclusive fill, silent write, dirty flush on snooped read
    do_cpu("R2", 2'd0, 8'h0A, 0, 1'b0);
    do_snoop("R6", 2'd0, 8'h0A);
    do_cpu("R4", 2'd1, 8'h0A, 16'h1111, 1'b0);
    do_cpu("R2", 2'd0, 8'h13, 0, 1'b0);
    do_cpu("R3", 2'd1, 8'h13, 16'h2222, 1'b0);
    do_cpu("R3", 2'd3, 8'h13, 0, 1'b0);
    do_snoop("R6", 2'd0, 8'h13);
    do_snoop("R8", 2'd2, 8'h0A);
    do_cpu("R8", 2'd0, 8'h0A, 0, 1'b0);
    do_snoop("R12", 2'd3, 8'h0A);
    do_snoop("R12", 2'd0, 8'h12);
    do_cpu("R12", 2'd0, 8'h0A, 0, 1'b0);
    do_cpu("R9", 2'd2, 8'h0A, 0, 1'b0);
    do_cpu("R9", 2'd2, 8'h13, 0, 1'b0);
    do_cpu("R9", 2'd2, 8'h24, 0, 1'b0);
    // dirty victim then fill
    do_cpu("R4", 2'd1, 8'h04, 16'h3333, 1'b0);
    do_cpu("R10", 2'd0, 8'h0C, 0, 1'b1);
    do_cpu("R10", 2'd1, 8'h14, 16'h4444, 1'b0);
    do_snoop("R7", 2'd1, 8'h14);
    do_cpu("R7", 2'd0, 8'h14, 0, 1'b1);
    do_snoop("R7", 2'd2, 8'h14);
    // pending upgrade loses its line
    do_cpu("R2", 2'd0, 8'h25, 0, 1'b1);
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_op = 2'd1; cpu_req_addr = 8'h25; cpu_req_wdata = 16'h5555;
    @(negedge clk);
    cpu_req_valid = 0;
    @(negedge clk);
    chk("R4", "upgrade cmd", bus_req_cmd, 2'd2);
    chk("R11", "req valid", bus_req_valid, 1);
    snp_valid = 1; snp_cmd = 2'd1; snp_addr = 8'h25;
    #(CLK_NS/4) chk("R7", "no flush on S", snp_flush_valid, 0);
    @(negedge clk);
    snp_valid = 0;
    chk("R11", "req held", bus_req_valid, 1);
    chk("R5", "converted cmd", bus_req_cmd, 2'd1);
    chk("R11", "addr held", bus_req_addr, 8'h25);
    bus_req_ready = 1;
    @(negedge clk);
    bus_req_ready = 0;
    chk("R5", "rsp valid", cpu_rsp_valid, 1);
    chk("R5", "rsp data", cpu_rsp_data, 16'h5555);
    m_st[5] = MM; m_tag[5] = 5'h04; m_dat[5] = 16'h5555;
    do_snoop("R6", 2'd0, 8'h25);
    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [AW-1:0] a = {5'($urandom % 3), 3'($urandom)};
      int pick = $urandom % 5;
      if (pick < 3) do_cpu("R2-mix", 2'($urandom), a, DW'($urandom), 1'($urandom));
      else do_snoop("R6-mix", 2'($urandom), a);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule